// File: doc/BRIEF.md
# Eight-Bit Timer with Compare Match Suppression

This block is an up-counter paired with a compare register. Each pulse on the timer enable input advances the counter by one. The counter wraps from its top value back to zero. On every timer pulse, the current counter value is compared with the compare register. An equal value counts as a match: it sets a sticky interrupt flag and, when enabled, toggles a waveform output.

Software uses a small register port to read and write the counter and the compare value. The same port clears the flag and enables the toggle output. A software write to the counter masks the compare on the next timer pulse. Loading a value equal to the compare value therefore does not fire a match. A load that jumps over the compare value skips that match altogether.

Top module: `tmr8_cmp`

## Requirements
- R1: After reset, the counter, compare register, interrupt flag, toggle enable and waveform output are all zero.
- R2: A bus write to address 0 loads the counter and a write to address 1 loads the compare register. A read of either address returns the stored value on `bus_rdata` combinationally.
- R3: On each cycle with `tick` high and no counter write, the counter increments by one and wraps from 255 to 0. Without `tick`, the counter holds its value.
- R4: A counter write in the same cycle as `tick` loads the written value, and no increment takes place.
- R5: A `tick` with counter equal to compare, and no suppression active, sets `irq_flag` on that clock edge.
- R6: A counter write suppresses the compare on the first `tick` after it, and also on a `tick` in the write cycle itself. After one suppressed tick, compares work normally again.
- R7: A counter write that jumps past the compare value means no match occurs until the counter reaches that value again.
- R8: Writing a value with bit 0 set to address 2 clears `irq_flag`. A match in the same cycle wins over the clear.
- R9: With address 3 bit 0 set, each unsuppressed match inverts `wave_out`. With that bit clear, `wave_out` holds while the flag is still set.
- R10: Reading address 2 returns the flag in bit 0, and reading address 3 returns the toggle enable in bit 0. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable, one pulse per count |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_flag | output | 1 | Sticky compare-match flag |
| wave_out | output | 1 | Waveform output toggled on match |

## Verification
The counter is run across the wrap point and with ticks held off. This separates proper increment and wrap from free running or lost counts. Compare is exercised in four ways: plain counting onto the compare value, loading exactly the compare value, loading with a simultaneous tick, and loading past the compare value. Together these separate a real match from a suppressed match, a suppression that lasts too long, and a skipped match. Flag clearing is tried alone and against a coincident match to expose the priority. Toggling is tried with the enable on and off.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CNT = 2'd0,
    REG_CMP = 2'd1,
    REG_FLG = 2'd2,
    REG_CTL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      cnt,
  input  logic              flag,
  output logic [W-1:0]      bus_rdata,
  output logic              cnt_ld,
  output logic [W-1:0]      cmp,
  output logic              tgl_en,
  output logic              flag_clr
);
  logic [W-1:0] cmp_d;
  logic         tgl_d;
  logic         cmp_we;
  logic         ctl_we;
  reg_sel_e     sel;

  assign sel      = reg_sel_e'(bus_addr);
  assign cnt_ld   = bus_wr && (sel == REG_CNT);
  assign cmp_we   = bus_wr && (sel == REG_CMP);
  assign ctl_we   = bus_wr && (sel == REG_CTL);
  assign flag_clr = bus_wr && (sel == REG_FLG) && bus_wdata[0];

  always_comb begin
    cmp_d = cmp;
    tgl_d = tgl_en;
    if (cmp_we) cmp_d = bus_wdata;
    if (ctl_we) tgl_d = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp    <= '0;
      tgl_en <= 1'b0;
    end else begin
      cmp    <= cmp_d;
      tgl_en <= tgl_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      REG_CNT: bus_rdata = cnt;
      REG_CMP: bus_rdata = cmp;
      REG_FLG: bus_rdata[0] = flag;
      REG_CTL: bus_rdata[0] = tgl_en;
      default: bus_rdata = '0;
    endcase
  end

  a_r2_cmp_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> cmp == $past(bus_wdata));
  a_r2_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_we |=> $stable(cmp));
endmodule

// File: rtl/tmr8_count.sv
module tmr8_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         blk
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_d;
  logic         blk_d;

  always_comb begin
    cnt_d = cnt;
    blk_d = blk;
    if (ld) begin
      cnt_d = ld_val;
      blk_d = 1'b1;
    end else if (tick) begin
      cnt_d = cnt + ONE;
      blk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      blk <= 1'b0;
    end else begin
      cnt <= cnt_d;
      blk <= blk_d;
    end
  end

  a_r3_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld) |=> cnt == W'($past(cnt) + ONE));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld) |=> $stable(cnt));
  a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(ld_val));
endmodule

// File: rtl/tmr8_match.sv
module tmr8_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld,
  input  logic         blk,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         tgl_en,
  input  logic         clr,
  output logic         flag,
  output logic         wave
);
  logic hit;
  logic flag_d;
  logic wave_d;

  assign hit = tick && !ld && !blk && (cnt == cmp);

  always_comb begin
    flag_d = flag;
    wave_d = wave;
    if (clr) flag_d = 1'b0;
    if (hit) begin
      flag_d = 1'b1;
      if (tgl_en) wave_d = !wave;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      wave <= 1'b0;
    end else begin
      flag <= flag_d;
      wave <= wave_d;
    end
  end

  a_r5_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && !blk && cnt == cmp) |=> flag);
  a_r6_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (ld || blk)) |=> $stable(wave));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !tick) |=> !flag);
  a_r9_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !tgl_en |=> $stable(wave));
endmodule

// File: rtl/tmr8_cmp.sv
module tmr8_cmp
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              irq_flag,
  output logic              wave_out
);
  logic [W-1:0] cnt;
  logic [W-1:0] cmp;
  logic         cnt_ld;
  logic         blk;
  logic         tgl_en;
  logic         flag_clr;

  tmr8_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .cnt(cnt), .flag(irq_flag), .bus_rdata(bus_rdata),
    .cnt_ld(cnt_ld), .cmp(cmp), .tgl_en(tgl_en), .flag_clr(flag_clr)
  );

  tmr8_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld(cnt_ld), .ld_val(bus_wdata),
    .cnt(cnt), .blk(blk)
  );

  tmr8_match #(.W(W)) u_match (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld(cnt_ld), .blk(blk),
    .cnt(cnt), .cmp(cmp), .tgl_en(tgl_en), .clr(flag_clr),
    .flag(irq_flag), .wave(wave_out)
  );

  a_r6_load_then_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ld && !irq_flag) ##1 (tick && !cnt_ld) |=> !irq_flag);
endmodule

// File: tb/tmr8_cmp_tb.sv
module tmr8_cmp_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_flag;
  logic       wave_out;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr8_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_flag(irq_flag), .wave_out(wave_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit wr, input logic [1:0] a, input logic [7:0] d, input bit t);
    bus_wr = wr; bus_addr = a; bus_wdata = d; tick = t;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'd0, 1'b1);
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic t_reset();
    int v;
    rd(2'd0, v); chk("R1 cnt", v, 0);
    rd(2'd1, v); chk("R1 cmp", v, 0);
    rd(2'd3, v); chk("R1 tgl", v, 0);
    chk("R1 flag", irq_flag, 0);
    chk("R1 wave", wave_out, 0);
  endtask

  task automatic t_rw_wrap();
    int v;
    cyc(1'b1, 2'd1, 8'd100, 1'b0);
    cyc(1'b1, 2'd0, 8'd250, 1'b0);
    rd(2'd1, v); chk("R2 cmp read", v, 100);
    rd(2'd0, v); chk("R2 cnt read", v, 250);
    ticks(10);
    rd(2'd0, v); chk("R3 wrap", v, 4);
    cyc(1'b0, 2'd0, 8'd0, 1'b0);
    cyc(1'b0, 2'd0, 8'd0, 1'b0);
    rd(2'd0, v); chk("R3 hold", v, 4);
    chk("R5 no match", irq_flag, 0);
  endtask

  task automatic t_match();
    int v;
    cyc(1'b1, 2'd3, 8'd1, 1'b0);
    cyc(1'b1, 2'd1, 8'd20, 1'b0);
    cyc(1'b1, 2'd0, 8'd18, 1'b0);
    ticks(2);
    chk("R5 before", irq_flag, 0);
    ticks(1);
    chk("R5 flag", irq_flag, 1);
    chk("R9 toggle", wave_out, 1);
    rd(2'd0, v); chk("R5 cnt", v, 21);
    rd(2'd2, v); chk("R10 flag read", v, 1);
    cyc(1'b1, 2'd2, 8'd1, 1'b0);
    chk("R8 clear", irq_flag, 0);
  endtask

  task automatic t_block();
    int v;
    cyc(1'b1, 2'd0, 8'd20, 1'b0);
    ticks(1);
    chk("R6 blocked flag", irq_flag, 0);
    chk("R6 blocked wave", wave_out, 1);
    cyc(1'b1, 2'd1, 8'd50, 1'b0);
    cyc(1'b1, 2'd0, 8'd50, 1'b1);
    rd(2'd0, v); chk("R4 load wins", v, 50);
    ticks(1);
    chk("R6 tick after same-cycle load", irq_flag, 0);
    rd(2'd0, v); chk("R6 cnt", v, 51);
    cyc(1'b1, 2'd0, 8'd49, 1'b0);
    ticks(2);
    chk("R6 block expires", irq_flag, 1);
    chk("R9 toggle back", wave_out, 0);
    cyc(1'b1, 2'd2, 8'd1, 1'b0);
  endtask

  task automatic t_skip();
    int v;
    cyc(1'b1, 2'd1, 8'd20, 1'b0);
    cyc(1'b1, 2'd0, 8'd10, 1'b0);
    ticks(5);
    cyc(1'b1, 2'd0, 8'd30, 1'b0);
    ticks(10);
    rd(2'd0, v); chk("R7 cnt", v, 40);
    chk("R7 skipped", irq_flag, 0);
  endtask

  task automatic t_clear_prio();
    cyc(1'b1, 2'd0, 8'd19, 1'b0);
    ticks(1);
    cyc(1'b1, 2'd2, 8'd1, 1'b1);
    chk("R8 set wins", irq_flag, 1);
    chk("R9 toggle", wave_out, 1);
  endtask

  task automatic t_no_toggle();
    int v;
    cyc(1'b1, 2'd3, 8'd0, 1'b0);
    cyc(1'b1, 2'd2, 8'd1, 1'b0);
    cyc(1'b1, 2'd0, 8'd19, 1'b0);
    ticks(2);
    chk("R9 flag", irq_flag, 1);
    chk("R9 wave held", wave_out, 1);
    rd(2'd3, v); chk("R10 ctl read", v, 0);
    rd(2'd2, v); chk("R10 flag read", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw_wrap();
    t_match();
    t_block();
    t_skip();
    t_clear_prio();
    t_no_toggle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule